// File: doc/BRIEF.md
# Character LCD Instruction Decoder

This block is the controller side of a character display module. A host drives an 8-bit byte, a register-select line and an enable strobe. Each byte is taken on the falling edge of the strobe. With register-select low the byte is an instruction. The block decodes it and updates its mode and address state. With register-select high the byte is character data. It is stored in an 80-cell text memory or in a 64-byte glyph memory, at the current address, and the address then steps.

The pixel driver that follows uses several outputs of this block. It reads the text and glyph memories through two combinational read ports. It also uses the cursor address, the display shift offset, the on/off flags for display, cursor and blink, the interface/line/font fields, and a blink phase bit. The blink phase bit toggles once per blink interval. The interval is a parameter counted in clock cycles, and its default is 409.6 ms at 250 MHz.

Top module: `lcd_cmd_engine`

## Requirements
- R1: A byte is taken only at a falling edge of `bus_en`, which is a clock edge where `bus_en` is low and was high at the previous edge. While `bus_en` stays high, the state and the memories do not change.
- R2: An instruction is decoded by its highest set bit: 7 set DD address, 6 set CG address, 5 function set, 4 cursor/display shift, 3 display control, 2 entry mode, 1 return home, 0 clear. The byte 0x00 changes nothing.
- R3: Clear (highest bit 0) writes 0x20 into all 80 text cells and sets `cursor_addr` and `shift_ofs` to 0. The glyph memory is left unchanged.
- R4: Return home (highest bit 1) sets `cursor_addr` and `shift_ofs` to 0 and leaves both memories unchanged.
- R5: Entry mode sets `inc_mode` from bit 1 and `auto_shift` from bit 0. Each text write stores the byte at `cursor_addr`. The address then moves +1 when `inc_mode`=1 and -1 when `inc_mode`=0, modulo 128.
- R6: When `auto_shift`=1, each text write also changes `shift_ofs`. It becomes (ofs+1) mod 80 when `inc_mode`=1 and (ofs+79) mod 80 when `inc_mode`=0.
- R7: The shift instruction does not touch either memory. With bit 3 = 0 it moves `cursor_addr` -1 (bit 2 = 0) or +1 (bit 2 = 1), modulo 128. With bit 3 = 1 it leaves the address alone and sets `shift_ofs` to (ofs+79) mod 80 when bit 2 = 1 (display moves right) or to (ofs+1) mod 80 when bit 2 = 0 (display moves left).
- R8: Display control loads `disp_en`, `cursor_en` and `blink_en` from bits 2, 1 and 0. Turning the display off and on again keeps the text memory contents.
- R9: Function set loads `wide_bus`, `two_lines` and `tall_font` from bits 4, 3 and 2.
- R10: Set CG address loads `cg_addr` from bits 5:0 and sets `cg_selected`. Set DD address loads `cursor_addr` from bits 6:0 and clears `cg_selected`. While `cg_selected`=1, data writes go to the glyph memory at `cg_addr`. `cg_addr` then steps ±1 modulo 64 according to `inc_mode`, and `shift_ofs` does not change.
- R11: A text write at an address of 80 or more stores nothing, but the address still steps. A text read at such an address returns 0x20.
- R12: While `blink_en`=1, `blink_phase` toggles every BLINK_CYC clock cycles, starting at 0 when blink is turned on. While `blink_en`=0, it is 0.
- R13: After reset: `wide_bus`=1, `two_lines`=0, `tall_font`=0, display/cursor/blink off, `inc_mode`=1, `auto_shift`=0, `cursor_addr`=0, `cg_addr`=0, `cg_selected`=0, `shift_ofs`=0, all text cells 0x20 and all glyph bytes 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rs | input | 1 | Register select: 0 instruction, 1 data |
| bus_en | input | 1 | Enable strobe, byte taken on its falling edge |
| bus_data | input | 8 | Byte from the host |
| dd_rd_addr | input | 7 | Text memory read address |
| dd_rd_data | output | 8 | Text memory read data |
| cg_rd_addr | input | 6 | Glyph memory read address |
| cg_rd_data | output | 8 | Glyph memory read data |
| cursor_addr | output | 7 | Text address counter |
| cg_addr | output | 6 | Glyph address counter |
| cg_selected | output | 1 | Data writes target glyph memory |
| inc_mode | output | 1 | Address steps up on writes |
| auto_shift | output | 1 | Display shifts on text writes |
| disp_en | output | 1 | Display on |
| cursor_en | output | 1 | Cursor on |
| blink_en | output | 1 | Cursor cell blink on |
| shift_ofs | output | 7 | Display shift offset, 0..79 |
| wide_bus | output | 1 | 8-bit interface field |
| two_lines | output | 1 | Two-line field |
| tall_font | output | 1 | Tall font field |
| blink_phase | output | 1 | Blink phase, 1 = cell blanked |

## Verification
A wrong address counter shows on `cursor_addr` right after the byte that moved it. It also puts the next data byte into the wrong cell, and that cell can be seen through the read port at any later point. A decode error in a mode field shows on the flag outputs after the next strobe, and it changes how every later write steps and shifts. The bench sweeps all 256 instruction codes, each followed by a data write, and it dumps both memories at the end. A blink prescaler that is wrong by even one cycle changes the measured toggle interval.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int AC_W = 7;
  localparam logic [7:0] BLANK_CHAR = 8'h20;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADDR, OP_DDADDR, OP_WDATA
  } lcd_op_e;
endpackage

// File: rtl/lcd_op_decode.sv
module lcd_op_decode
  import lcd_pkg::*;
(
  input  logic       rs,
  input  logic [7:0] byte_in,
  output lcd_op_e    op
);
  always_comb begin
    if (rs)              op = OP_WDATA;
    else if (byte_in[7]) op = OP_DDADDR;
    else if (byte_in[6]) op = OP_CGADDR;
    else if (byte_in[5]) op = OP_FUNC;
    else if (byte_in[4]) op = OP_SHIFT;
    else if (byte_in[3]) op = OP_DISP;
    else if (byte_in[2]) op = OP_ENTRY;
    else if (byte_in[1]) op = OP_HOME;
    else if (byte_in[0]) op = OP_CLEAR;
    else                 op = OP_NONE;
  end
endmodule

// File: rtl/lcd_text_ram.sv
module lcd_text_ram
  import lcd_pkg::*;
#(
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        dd_we,
  input  logic [AC_W-1:0]             dd_wa,
  input  logic                        cg_we,
  input  logic [$clog2(CG_DEPTH)-1:0] cg_wa,
  input  logic [7:0]                  wd,
  input  logic [AC_W-1:0]             dd_ra,
  output logic [7:0]                  dd_rd,
  input  logic [$clog2(CG_DEPTH)-1:0] cg_ra,
  output logic [7:0]                  cg_rd
);
  localparam logic [AC_W-1:0] DD_LIMIT = AC_W'(DD_DEPTH);

  logic [7:0] dd_mem [DD_DEPTH];
  logic [7:0] cg_mem [CG_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK_CHAR;
    end else if (clr) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK_CHAR;
    end else if (dd_we && (dd_wa < DD_LIMIT)) begin
      dd_mem[dd_wa] <= wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CG_DEPTH; i++) cg_mem[i] <= 8'h00;
    end else if (cg_we) begin
      cg_mem[cg_wa] <= wd;
    end
  end

  assign dd_rd = (dd_ra < DD_LIMIT) ? dd_mem[dd_ra] : BLANK_CHAR;
  assign cg_rd = cg_mem[cg_ra];
endmodule

// File: rtl/lcd_blink_timer.sv
module lcd_blink_timer #(
  parameter int BLINK_CYC = 102_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic phase
);
  localparam int CW = (BLINK_CYC > 1) ? $clog2(BLINK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLINK_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!enable) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/lcd_cmd_engine.sv
module lcd_cmd_engine
  import lcd_pkg::*;
#(
  parameter int DD_DEPTH  = 80,
  parameter int CG_DEPTH  = 64,
  parameter int BLINK_CYC = 102_400_000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_rs,
  input  logic                        bus_en,
  input  logic [7:0]                  bus_data,
  input  logic [AC_W-1:0]             dd_rd_addr,
  output logic [7:0]                  dd_rd_data,
  input  logic [$clog2(CG_DEPTH)-1:0] cg_rd_addr,
  output logic [7:0]                  cg_rd_data,
  output logic [AC_W-1:0]             cursor_addr,
  output logic [$clog2(CG_DEPTH)-1:0] cg_addr,
  output logic                        cg_selected,
  output logic                        inc_mode,
  output logic                        auto_shift,
  output logic                        disp_en,
  output logic                        cursor_en,
  output logic                        blink_en,
  output logic [AC_W-1:0]             shift_ofs,
  output logic                        wide_bus,
  output logic                        two_lines,
  output logic                        tall_font,
  output logic                        blink_phase
);
  localparam int CG_AW = $clog2(CG_DEPTH);
  localparam logic [AC_W-1:0] OFS_MAX = AC_W'(DD_DEPTH - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // strobe edge detect
  logic en_q, accept;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) en_q <= 1'b0;
    else          en_q <= bus_en;
  end
  assign accept = en_q & ~bus_en;

  lcd_op_e op;
  lcd_op_decode u_dec (.rs(bus_rs), .byte_in(bus_data), .op(op));

  // state
  logic [AC_W-1:0]  ac_q, ac_d, ofs_q, ofs_d, ofs_lt, ofs_rt;
  logic [CG_AW-1:0] cga_q, cga_d;
  logic sel_q, sel_d, id_q, id_d, sh_q, sh_d;
  logic d_q, d_d, c_q, c_d, b_q, b_d;
  logic dl_q, dl_d, n_q, n_d, f_q, f_d;
  logic clr, dd_we, cg_we;

  assign ofs_lt = (ofs_q == OFS_MAX) ? '0 : ofs_q + 1'b1;
  assign ofs_rt = (ofs_q == '0) ? OFS_MAX : ofs_q - 1'b1;

  always_comb begin
    ac_d = ac_q;  ofs_d = ofs_q; cga_d = cga_q; sel_d = sel_q;
    id_d = id_q;  sh_d = sh_q;   d_d = d_q;     c_d = c_q;  b_d = b_q;
    dl_d = dl_q;  n_d = n_q;     f_d = f_q;
    clr = 1'b0;   dd_we = 1'b0;  cg_we = 1'b0;
    if (accept) begin
      case (op)
        OP_CLEAR: begin clr = 1'b1; ac_d = '0; ofs_d = '0; end
        OP_HOME:  begin ac_d = '0; ofs_d = '0; end
        OP_ENTRY: begin id_d = bus_data[1]; sh_d = bus_data[0]; end
        OP_DISP:  begin
          d_d = bus_data[2]; c_d = bus_data[1]; b_d = bus_data[0];
        end
        OP_SHIFT: begin
          if (!bus_data[3]) ac_d = bus_data[2] ? ac_q + 1'b1 : ac_q - 1'b1;
          else              ofs_d = bus_data[2] ? ofs_rt : ofs_lt;
        end
        OP_FUNC:  begin
          dl_d = bus_data[4]; n_d = bus_data[3]; f_d = bus_data[2];
        end
        OP_CGADDR: begin cga_d = bus_data[CG_AW-1:0]; sel_d = 1'b1; end
        OP_DDADDR: begin ac_d = bus_data[AC_W-1:0]; sel_d = 1'b0; end
        OP_WDATA: begin
          if (sel_q) begin
            cg_we = 1'b1;
            cga_d = id_q ? cga_q + 1'b1 : cga_q - 1'b1;
          end else begin
            dd_we = 1'b1;
            ac_d  = id_q ? ac_q + 1'b1 : ac_q - 1'b1;
            if (sh_q) ofs_d = id_q ? ofs_lt : ofs_rt;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ac_q <= '0;  ofs_q <= '0;  cga_q <= '0;  sel_q <= 1'b0;
      id_q <= 1'b1; sh_q <= 1'b0;
      d_q  <= 1'b0; c_q  <= 1'b0; b_q  <= 1'b0;
      dl_q <= 1'b1; n_q  <= 1'b0; f_q  <= 1'b0;
    end else if (accept) begin
      ac_q <= ac_d;  ofs_q <= ofs_d;  cga_q <= cga_d;  sel_q <= sel_d;
      id_q <= id_d;  sh_q  <= sh_d;
      d_q  <= d_d;   c_q   <= c_d;    b_q   <= b_d;
      dl_q <= dl_d;  n_q   <= n_d;    f_q   <= f_d;
    end
  end

  lcd_text_ram #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_i_n), .clr(clr),
    .dd_we(dd_we), .dd_wa(ac_q), .cg_we(cg_we), .cg_wa(cga_q),
    .wd(bus_data), .dd_ra(dd_rd_addr), .dd_rd(dd_rd_data),
    .cg_ra(cg_rd_addr), .cg_rd(cg_rd_data)
  );

  lcd_blink_timer #(.BLINK_CYC(BLINK_CYC)) u_blink (
    .clk(clk), .rst_n(rst_i_n), .enable(b_q), .phase(blink_phase)
  );

  assign cursor_addr = ac_q;
  assign cg_addr     = cga_q;
  assign cg_selected = sel_q;
  assign inc_mode    = id_q;
  assign auto_shift  = sh_q;
  assign disp_en     = d_q;
  assign cursor_en   = c_q;
  assign blink_en    = b_q;
  assign shift_ofs   = ofs_q;
  assign wide_bus    = dl_q;
  assign two_lines   = n_q;
  assign tall_font   = f_q;
endmodule

// File: rtl/lcd_cmd_engine_chk.sv
module lcd_cmd_engine_chk #(
  parameter int DD_DEPTH = 80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rs,
  input logic       bus_en,
  input logic [7:0] bus_data,
  input logic [6:0] cursor_addr,
  input logic [6:0] shift_ofs,
  input logic       cg_selected,
  input logic       inc_mode,
  input logic       blink_en,
  input logic       blink_phase
);
  logic en_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen <= 1'b0;
    else        en_seen <= bus_en;
  end

  logic take, take_text, take_glyph, take_home;
  assign take       = en_seen & ~bus_en;
  assign take_text  = take & bus_rs & ~cg_selected;
  assign take_glyph = take & bus_rs & cg_selected;
  assign take_home  = take & ~bus_rs & (bus_data[7:2] == 6'd0) & (bus_data[1:0] != 2'd0);

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> ($stable(cursor_addr) && $stable(shift_ofs))); // R1

  AST_HOME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take_home |=> (cursor_addr == 7'd0 && shift_ofs == 7'd0)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_text |=> (cursor_addr == ($past(inc_mode) ? $past(cursor_addr) + 7'd1
                                                   : $past(cursor_addr) - 7'd1))); // R5

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ofs < 7'(DD_DEPTH)); // R6

  AST_GLYPH_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    take_glyph |=> ($stable(shift_ofs) && $stable(cursor_addr))); // R10

  AST_BLINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_en |=> !blink_phase); // R12
endmodule

bind lcd_cmd_engine lcd_cmd_engine_chk #(.DD_DEPTH(DD_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_en(bus_en),
  .bus_data(bus_data), .cursor_addr(cursor_addr), .shift_ofs(shift_ofs),
  .cg_selected(cg_selected), .inc_mode(inc_mode), .blink_en(blink_en),
  .blink_phase(blink_phase)
);

// File: tb/lcd_cmd_engine_test.sv
module lcd_cmd_engine_test;
  localparam int BC = 8;

  logic clk = 1'b0;
  logic rst_n, bus_rs, bus_en;
  logic [7:0] bus_data, dd_rd_data, cg_rd_data;
  logic [6:0] dd_rd_addr, cursor_addr, shift_ofs;
  logic [5:0] cg_rd_addr, cg_addr;
  logic cg_selected, inc_mode, auto_shift, disp_en, cursor_en, blink_en;
  logic wide_bus, two_lines, tall_font, blink_phase;

  always #2 clk = ~clk;

  lcd_cmd_engine #(.DD_DEPTH(80), .CG_DEPTH(64), .BLINK_CYC(BC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_en(bus_en),
    .bus_data(bus_data), .dd_rd_addr(dd_rd_addr), .dd_rd_data(dd_rd_data),
    .cg_rd_addr(cg_rd_addr), .cg_rd_data(cg_rd_data),
    .cursor_addr(cursor_addr), .cg_addr(cg_addr), .cg_selected(cg_selected),
    .inc_mode(inc_mode), .auto_shift(auto_shift), .disp_en(disp_en),
    .cursor_en(cursor_en), .blink_en(blink_en), .shift_ofs(shift_ofs),
    .wide_bus(wide_bus), .two_lines(two_lines), .tall_font(tall_font),
    .blink_phase(blink_phase)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference model
  int m_ac, m_ofs, m_cga;
  bit m_sel, m_id, m_sh, m_d, m_c, m_b, m_dl, m_n, m_f;
  int m_dd [80];
  int m_cg [64];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ac = 0; m_ofs = 0; m_cga = 0; m_sel = 0; m_id = 1; m_sh = 0;
    m_d = 0; m_c = 0; m_b = 0; m_dl = 1; m_n = 0; m_f = 0;
    for (int i = 0; i < 80; i++) m_dd[i] = 32;
    for (int i = 0; i < 64; i++) m_cg[i] = 0;
  endtask

  task automatic model(input bit rs, input logic [7:0] d);
    if (rs) begin
      if (m_sel) begin
        m_cg[m_cga] = d;
        m_cga = m_id ? (m_cga + 1) % 64 : (m_cga + 63) % 64;
      end else begin
        if (m_ac < 80) m_dd[m_ac] = d;
        m_ac = m_id ? (m_ac + 1) % 128 : (m_ac + 127) % 128;
        if (m_sh) m_ofs = m_id ? (m_ofs + 1) % 80 : (m_ofs + 79) % 80;
      end
    end else if (d[7]) begin m_ac = d[6:0]; m_sel = 0; end
    else if (d[6]) begin m_cga = d[5:0]; m_sel = 1; end
    else if (d[5]) begin m_dl = d[4]; m_n = d[3]; m_f = d[2]; end
    else if (d[4]) begin
      if (!d[3]) m_ac = d[2] ? (m_ac + 1) % 128 : (m_ac + 127) % 128;
      else       m_ofs = d[2] ? (m_ofs + 79) % 80 : (m_ofs + 1) % 80;
    end
    else if (d[3]) begin m_d = d[2]; m_c = d[1]; m_b = d[0]; end
    else if (d[2]) begin m_id = d[1]; m_sh = d[0]; end
    else if (d[1]) begin m_ac = 0; m_ofs = 0; end
    else if (d[0]) begin
      m_ac = 0; m_ofs = 0;
      for (int i = 0; i < 80; i++) m_dd[i] = 32;
    end
  endtask

  task automatic wr(input bit rs, input logic [7:0] d);
    bus_rs = rs; bus_data = d; bus_en = 1'b1;
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
    model(rs, d);
  endtask

  task automatic chk_state(input string tag);
    chk(tag, "cursor_addr", int'(cursor_addr), m_ac);
    chk(tag, "shift_ofs",   int'(shift_ofs),   m_ofs);
    chk(tag, "cg_addr",     int'(cg_addr),     m_cga);
    chk(tag, "cg_selected", int'(cg_selected), int'(m_sel));
    chk(tag, "inc_mode",    int'(inc_mode),    int'(m_id));
    chk(tag, "auto_shift",  int'(auto_shift),  int'(m_sh));
    chk(tag, "disp_en",     int'(disp_en),     int'(m_d));
    chk(tag, "cursor_en",   int'(cursor_en),   int'(m_c));
    chk(tag, "blink_en",    int'(blink_en),    int'(m_b));
    chk(tag, "wide_bus",    int'(wide_bus),    int'(m_dl));
    chk(tag, "two_lines",   int'(two_lines),   int'(m_n));
    chk(tag, "tall_font",   int'(tall_font),   int'(m_f));
  endtask

  task automatic chk_mem(input string tag);
    for (int i = 0; i < 128; i++) begin
      dd_rd_addr = 7'(i); #1;
      chk(tag, $sformatf("text[%0d]", i), int'(dd_rd_data), (i < 80) ? m_dd[i] : 32);
    end
    for (int i = 0; i < 64; i++) begin
      cg_rd_addr = 6'(i); #1;
      chk(tag, $sformatf("glyph[%0d]", i), int'(cg_rd_data), m_cg[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_rs = 1'b0; bus_en = 1'b0; bus_data = 8'h00;
    dd_rd_addr = '0; cg_rd_addr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    chk_state("R13");
    chk("R13", "blink_phase", int'(blink_phase), 0);
    chk_mem("R13");

    // R1: strobe held high changes nothing
    bus_rs = 1'b0; bus_data = 8'h80 | 8'd37; bus_en = 1'b1;
    repeat (4) @(negedge clk);
    chk_state("R1");
    bus_en = 1'b0; @(negedge clk);
    model(1'b0, 8'h80 | 8'd37);
    chk_state("R1");
    repeat (3) @(negedge clk);
    chk_state("R1");

    // R2 / R5..R10: sweep of every instruction code, each followed by a data byte
    for (int c = 0; c < 256; c++) begin
      wr(1'b0, 8'(c));
      chk_state("R2");
      wr(1'b1, 8'(c) ^ 8'h5A);
      chk_state("R2");
    end
    chk_mem("R2");

    // R3: clear blanks text, keeps glyphs
    wr(1'b0, 8'h40 | 8'd5); wr(1'b1, 8'hC3);
    wr(1'b0, 8'h80 | 8'd10); wr(1'b1, 8'h41); wr(1'b1, 8'h42);
    wr(1'b0, 8'h01);
    chk_state("R3");
    chk_mem("R3");

    // R4: home keeps memory
    wr(1'b0, 8'h06); wr(1'b0, 8'h80 | 8'd20);
    wr(1'b1, 8'h61); wr(1'b1, 8'h62); wr(1'b0, 8'h18);
    wr(1'b0, 8'h02);
    chk_state("R4");
    chk_mem("R4");

    // R5 decrement wrap at address 0
    wr(1'b0, 8'h04); wr(1'b0, 8'h80); wr(1'b1, 8'h33);
    chk("R5", "cursor_addr wrap", int'(cursor_addr), 127);
    chk_state("R5");

    // R6 shift wraps: decrement with shift from offset 0, then increment from 79
    wr(1'b0, 8'h02); wr(1'b0, 8'h05); wr(1'b0, 8'h80 | 8'd3); wr(1'b1, 8'h34);
    chk("R6", "shift_ofs", int'(shift_ofs), 79);
    wr(1'b0, 8'h07); wr(1'b1, 8'h35);
    chk("R6", "shift_ofs", int'(shift_ofs), 0);
    chk_state("R6");

    // R7 cursor and display shifts
    wr(1'b0, 8'h06); wr(1'b0, 8'h80 | 8'd50);
    wr(1'b0, 8'h14); chk("R7", "cursor right", int'(cursor_addr), 51);
    wr(1'b0, 8'h10); wr(1'b0, 8'h10); chk("R7", "cursor left", int'(cursor_addr), 49);
    wr(1'b0, 8'h1C); chk("R7", "display right", int'(shift_ofs), 79);
    wr(1'b0, 8'h18); wr(1'b0, 8'h18); chk("R7", "display left", int'(shift_ofs), 1);
    chk_state("R7");
    chk_mem("R7");

    // R8 display off/on keeps text
    wr(1'b0, 8'h80); wr(1'b1, 8'h4B);
    wr(1'b0, 8'h08); chk_state("R8");
    wr(1'b0, 8'h0E); chk_state("R8");
    chk_mem("R8");

    // R9 function set fields
    wr(1'b0, 8'h2C); chk_state("R9");
    wr(1'b0, 8'h30); chk_state("R9");

    // R10 glyph writes: decrement wrap, no shift
    wr(1'b0, 8'h05); wr(1'b0, 8'h40); wr(1'b1, 8'h1F);
    chk("R10", "cg_addr wrap", int'(cg_addr), 63);
    chk_state("R10");
    chk_mem("R10");

    // R11 writes beyond the text cells are dropped
    wr(1'b0, 8'h06); wr(1'b0, 8'h80 | 8'd79);
    wr(1'b1, 8'h71); wr(1'b1, 8'h72); wr(1'b1, 8'h73);
    chk("R11", "cursor_addr", int'(cursor_addr), 82);
    chk_state("R11");
    chk_mem("R11");

    // R12 blink timing
    wr(1'b0, 8'h0C); @(negedge clk);
    chk("R12", "blink_phase idle", int'(blink_phase), 0);
    wr(1'b0, 8'h0D);
    begin
      int k = 0;
      while (!blink_phase && k < 100) begin @(negedge clk); k++; end
      chk("R12", "cycles to first toggle", k, BC);
      k = 0;
      while (blink_phase && k < 100) begin @(negedge clk); k++; end
      chk("R12", "cycles to second toggle", k, BC);
    end
    wr(1'b0, 8'h0C); @(negedge clk);
    chk("R12", "blink_phase off", int'(blink_phase), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule